// File: doc/BRIEF.md
# Synchronous Pipelined SRAM Core

This block is a synthesizable behavioural model of a clocked single-port static memory. Every access is qualified by three chip enables and a sleep input, and every input is sampled on the rising clock edge. Writes can be masked per byte lane. A global write strobe stores the whole word. A master enable, together with four per-lane strobes, stores only the chosen lanes. When a lane is 9 bits wide, its ninth (parity) bit is stored with it.

Read data leaves the array through a capture register. A mode input chooses how it reaches the output. In pipelined mode a second output register adds one more stage. In flow-through mode the capture register drives the output directly. The output bus is modelled as data plus a valid flag. The output enable gates both without reference to the clock, and the data reads as zero whenever the bus would be undriven. The address comes from a separate burst-sequencing block.

Top module: `sync_sram_core`

## Requirements
- R1: While `rst_n` is low, `rvalid` is 0 and `rdata` is all zeros.
- R2: In pipelined mode (`flow_thru`=0), data for a read command sampled at edge k appears on `rdata` with `rvalid`=1 after edge k+1, and `rvalid` is still 0 after edge k.
- R3: In flow-through mode (`flow_thru`=1), data for a read command sampled at edge k appears with `rvalid`=1 after edge k.
- R4: With `gw_n`=1 and `bwe_n`=0, lane i (bits [i*BYTE_W +: BYTE_W]) is written exactly when `bw_n[i]`=0, and the other lanes keep their contents.
- R5: With `gw_n`=0, all lanes are written, whatever the values of `bwe_n` and `bw_n`.
- R6: A selected cycle is a read when `gw_n`=1 and no lane is enabled, either because `bwe_n`=1 (then `bw_n` is ignored) or because `bw_n`=4'b1111.
- R7: An access happens only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0. If any one of them is inactive, no lane is written and no read data is produced.
- R8: Deselect takes effect one cycle later. In pipelined mode, a read sampled just before a deselected edge still delivers its data, and `rvalid` drops after the edge that follows.
- R9: With `oe_n`=1, `rvalid` is 0 and `rdata` is zero at once, with no clock edge needed. Lowering `oe_n` restores pending data in the same way.
- R10: While `sleep`=1, no write or read is performed and memory contents are kept.
- R11: With `BYTE_W`=9, the parity bit (bit 9i+8) is written together with its lane.
- R12: A write cycle produces no read data in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the read-valid stages |
| addr | input | ADDR_W | Word address |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low, all lanes |
| bwe_n | input | 1 | Byte-write master enable, active low |
| bw_n | input | NBYTES | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| flow_thru | input | 1 | 1 = flow-through read path, 0 = pipelined |
| sleep | input | 1 | Power-down; blocks all accesses |
| wdata | input | NBYTES*BYTE_W | Write data |
| rdata | output | NBYTES*BYTE_W | Read data, zero when not valid |
| rvalid | output | 1 | Output bus is driven with read data |

## Verification
The bench builds the core with `ADDR_W`=8 and `BYTE_W`=9. The 36-bit word therefore has a parity bit in every lane, which makes it possible to check that bit 8 and bit 35 follow their lanes during masked writes. The small depth keeps elaboration light, and every address the bench touches is still distinct. Both read paths are exercised with the same stored words, so a latency off by one edge shows up as either early or missing data.

// File: rtl/sync_sram_core.sv
module sync_sram_core #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int DW    = BYTE_W * NBYTES,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              ce2_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic              oe_n,
  input  logic              flow_thru,
  input  logic              sleep,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] cap_q, out_q;
  logic          cap_v, out_v;

  wire              sel     = !ce0_n && ce1 && !ce2_n && !sleep;
  wire [NBYTES-1:0] lane_we = !gw_n ? {NBYTES{1'b1}} : (bwe_n ? '0 : ~bw_n);
  wire              rd_cmd  = sel && (lane_we == '0);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NBYTES; i++)
      if (sel && lane_we[i])
        mem[addr][i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rd_cmd) cap_q <= mem[addr];
    if (cap_v)  out_q <= cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_v <= 1'b0;
      out_v <= 1'b0;
    end else begin
      cap_v <= rd_cmd;
      out_v <= cap_v;
    end
  end

  assign rvalid = !oe_n && (flow_thru ? cap_v : out_v);
  assign rdata  = rvalid ? (flow_thru ? cap_q : out_q) : '0;

endmodule

module sync_sram_core_chk #(
  parameter int NBYTES = 4,
  parameter int DW     = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce0_n,
  input logic              ce1,
  input logic              ce2_n,
  input logic              gw_n,
  input logic              bwe_n,
  input logic [NBYTES-1:0] bw_n,
  input logic              oe_n,
  input logic              flow_thru,
  input logic              sleep,
  input logic [DW-1:0]     rdata,
  input logic              rvalid
);
  logic on, wr, rd;
  assign on = !ce0_n && ce1 && !ce2_n && !sleep;
  assign wr = on && (!gw_n || (!bwe_n && (bw_n != '1)));
  assign rd = on && !wr;

  a_r3_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (!flow_thru || oe_n || rvalid));
  a_r2_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> ##1 (flow_thru || oe_n || rvalid));
  a_r7_deselect_flow: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (!flow_thru || !rvalid));
  a_r12_write_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ##1 (flow_thru || !rvalid));
  a_r12_write_flow: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (!flow_thru || !rvalid));
  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rvalid && rdata == '0));
endmodule

bind sync_sram_core sync_sram_core_chk #(.NBYTES(NBYTES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
  .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
  .flow_thru(flow_thru), .sleep(sleep), .rdata(rdata), .rvalid(rvalid));

// File: tb/sync_sram_core_bench.sv
module sync_sram_core_bench;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic ce0_n = 1, ce1 = 0, ce2_n = 1, gw_n = 1, bwe_n = 1, oe_n = 0;
  logic flow_thru = 0, sleep = 0;
  logic [3:0] bw_n = 4'hF;
  logic [DW-1:0] wdata = '0, rdata;
  logic rvalid;
  int checks = 0, fails = 0;
  bit done = 0;

  sync_sram_core #(.ADDR_W(AW), .BYTE_W(9), .NBYTES(4)) u_sync_sram_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce0_n(ce0_n), .ce1(ce1),
    .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .flow_thru(flow_thru), .sleep(sleep), .wdata(wdata), .rdata(rdata),
    .rvalid(rvalid));

  always #5 clk = ~clk;

  // {chk, gw_n, bwe_n, bw_n[3:0], addr[7:0], wdata[35:0], expected[35:0]}
  localparam int NV = 10;
  localparam logic [86:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 4'b1111, 8'd5, 36'h123456789, 36'h0},          // R5
    {1'b1, 1'b1, 1'b1, 4'b1111, 8'd5, 36'h0,         36'h123456789},
    {1'b0, 1'b1, 1'b0, 4'b1110, 8'd5, 36'hFFFFFFFFF, 36'h0},          // R4 R11 lane 0
    {1'b1, 1'b1, 1'b1, 4'b1111, 8'd5, 36'h0,         36'h1234567FF},
    {1'b0, 1'b1, 1'b0, 4'b0111, 8'd5, 36'h000000000, 36'h0},          // R4 R11 lane 3
    {1'b1, 1'b1, 1'b1, 4'b1111, 8'd5, 36'h0,         36'h0034567FF},
    {1'b1, 1'b1, 1'b1, 4'b0000, 8'd5, 36'h0,         36'h0034567FF},  // R6 bw ignored
    {1'b1, 1'b1, 1'b0, 4'b1111, 8'd5, 36'h0,         36'h0034567FF},  // R6 no lane
    {1'b0, 1'b0, 1'b0, 4'b0000, 8'd9, 36'hFEDCBA987, 36'h0},          // R5
    {1'b1, 1'b1, 1'b1, 4'b1111, 8'd9, 36'h0,         36'hFEDCBA987}
  };

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic g, input logic b, input logic [3:0] w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0_n = 0; ce1 = 1; ce2_n = 0;
    gw_n = g; bwe_n = b; bw_n = w; addr = a; wdata = d;
  endtask

  task automatic idle();
    ce0_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
  endtask

  task automatic flow_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    flow_thru = 1;
    cmd(1, 1, 4'hF, a, '0);
    @(negedge clk);
    check(rvalid && rdata == exp, req, rdata, exp);
    idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!rvalid && rdata == '0, "R1 reset", rdata, '0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i][85], VEC[i][84], VEC[i][83:80], VEC[i][79:72], VEC[i][71:36]);
      @(negedge clk);
      if (VEC[i][86]) check(!rvalid, "R2 early", {35'b0, rvalid}, '0);
      idle();
      @(negedge clk);
      if (VEC[i][86]) check(rvalid && rdata == VEC[i][35:0], "R2,R4,R5,R6,R11 table", rdata, VEC[i][35:0]);
    end

    // R3 flow-through latency
    flow_read(8'd9, 36'hFEDCBA987, "R3 flow read");

    // R9 output enable without a clock edge
    cmd(1, 1, 4'hF, 8'd9, '0);
    @(negedge clk);
    oe_n = 1; #1;
    check(!rvalid && rdata == '0, "R9 oe high", rdata, '0);
    oe_n = 0; #1;
    check(rvalid && rdata == 36'hFEDCBA987, "R9 oe restore", rdata, 36'hFEDCBA987);
    idle();
    @(negedge clk);

    // R12 write cycle gives no read data (flow mode)
    cmd(0, 1, 4'hF, 8'd3, 36'h0AAAAAAAA);
    @(negedge clk);
    check(!rvalid, "R12 write flow", {35'b0, rvalid}, '0);
    idle();
    @(negedge clk);
    flow_read(8'd3, 36'h0AAAAAAAA, "R12 write stored");

    // R7 each chip enable blocks writes and reads
    for (int e = 0; e < 3; e++) begin
      cmd(0, 1, 4'hF, 8'd9, 36'h0);
      if (e == 0) ce0_n = 1; else if (e == 1) ce1 = 0; else ce2_n = 1;
      @(negedge clk);
      cmd(1, 1, 4'hF, 8'd9, '0);
      if (e == 0) ce0_n = 1; else if (e == 1) ce1 = 0; else ce2_n = 1;
      @(negedge clk);
      check(!rvalid, "R7 deselected read", {35'b0, rvalid}, '0);
      idle();
      flow_read(8'd9, 36'hFEDCBA987, "R7 deselected write");
    end

    // R10 sleep blocks writes and reads
    cmd(0, 1, 4'hF, 8'd9, 36'h0); sleep = 1;
    @(negedge clk);
    cmd(1, 1, 4'hF, 8'd9, '0);
    @(negedge clk);
    check(!rvalid, "R10 sleep read", {35'b0, rvalid}, '0);
    sleep = 0; idle();
    flow_read(8'd9, 36'hFEDCBA987, "R10 sleep write");

    // R8 pipelined deselect one cycle late
    flow_thru = 0;
    cmd(1, 1, 4'hF, 8'd3, '0);
    @(negedge clk);
    idle();
    @(negedge clk);
    check(rvalid && rdata == 36'h0AAAAAAAA, "R8 data after deselect", rdata, 36'h0AAAAAAAA);
    @(negedge clk);
    check(!rvalid, "R8 drop", {35'b0, rvalid}, '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule